// File: doc/BRIEF.md
# Two-Row-Buffer DRAM Bank Front End

This block sits in front of one single-ported DRAM bank that serves a simple processing element placed in memory. It keeps two open rows in local row buffers. A request (read or write of one 32-bit word, byte addressed) is taken over a valid/ready handshake. The block answers from a buffer when the row is already open. Otherwise it replaces one buffer and first writes that buffer back to the array if it holds modified data. Each request takes a fixed number of cycles: a short count on a buffer hit and a long count on a miss. The response comes back as a one-cycle pulse with the data.

The bank has one port, so only one request is in flight at a time. The requester sees `req_ready` low for the whole service window. A store is therefore never accepted before the previous store has reached a row buffer. Replacement fills an empty buffer first and otherwise evicts the less recently used one. Any write-back happens inside the miss window, so the miss latency does not change with the victim's state.

The array depth is a parameter. The default builds four rows of 2 KB to keep elaboration small. A full 1 MB bank uses `ROW_W = 9` with the same 11-bit column offset.

Top module: `dual_rb_bank_ctl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and both buffers are empty, so the first access to any row is a miss.
- R2: A request whose row is held in a buffer gets its response `HIT_LAT` (default 4) cycles after the accepting clock edge.
- R3: A request whose row is in neither buffer gets its response `MISS_LAT` (default 8) cycles after the accepting clock edge, whether or not the victim needs write-back.
- R4: `req_ready` is 0 from the accepting edge until the response cycle and is 1 again in that cycle, so at most one request (and so at most one store) is outstanding.
- R5: `rsp_valid` is high for exactly one cycle per request, and `rsp_rdata` changes only in a cycle where `rsp_valid` is high.
- R6: A read returns the word most recently written to the same address, including after that row has been evicted and reloaded (dirty rows are written back).
- R7: On a miss an empty buffer is filled first (buffer 0 before buffer 1); when both hold rows, the buffer not used by the most recent request is replaced.
- R8: The row is `req_addr[COL_W+ROW_W-1:COL_W]`, the word within the row is `req_addr[COL_W-1:2]` (COL_W = 11), and `req_addr[1:0]` has no effect.
- R9: A write's response pulse carries the written word on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Byte address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read word, or the written word for a write |

## Verification
A request is taken at the clock edge where `req_valid` and `req_ready` are both high. The response pulse is due after exactly 4 further edges on a hit and 8 on a miss. The bench samples at falling edges and counts edges from the accepting one. It checks that `req_ready` is low at every sample before the response and that the pulse appears at the count its own two-buffer model predicts. Read data is compared in that same response cycle against a shadow of every word the bench has written. Eviction order is checked only through these hit and miss latencies at the ports.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rbc_seq.sv
module rbc_seq
  import rbc_pkg::*;
#(
  parameter int HIT_LAT  = 4,
  parameter int MISS_LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_hit,
  output logic idle,
  output logic fill_en,
  output logic done_en
);
  localparam int CNT_W = $clog2(MISS_LAT + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fill_q, fill_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fill_d  = fill_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_BUSY;
          cnt_d   = start_hit ? CNT_W'(HIT_LAT - 1) : CNT_W'(MISS_LAT - 1);
          fill_d  = !start_hit;
        end
      end
      default: begin
        fill_d = 1'b0;
        if (cnt_q == '0) state_d = SEQ_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      fill_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fill_q  <= fill_d;
    end
  end

  assign idle    = (state_q == SEQ_IDLE);
  assign fill_en = (state_q == SEQ_BUSY) && fill_q;
  assign done_en = (state_q == SEQ_BUSY) && (cnt_q == '0);
endmodule

// File: rtl/rbc_tags.sv
module rbc_tags #(
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] look_row,
  output logic             hit,
  output logic             hit_idx,
  output logic             vict_idx,
  output logic             vict_wb,
  output logic [ROW_W-1:0] vict_row,
  input  logic             touch_en,
  input  logic             touch_idx,
  input  logic             fill_en,
  input  logic             fill_idx,
  input  logic [ROW_W-1:0] fill_row,
  input  logic             dirty_en,
  input  logic             dirty_idx
);
  localparam int NBUF = 2;

  logic [NBUF-1:0]  vld_q, drt_q, match;
  logic [ROW_W-1:0] tag_q [NBUF];
  logic             mru_q;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    assign match[b] = vld_q[b] && (tag_q[b] == look_row);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[b] <= 1'b0;
        drt_q[b] <= 1'b0;
        tag_q[b] <= '0;
      end else begin
        if (fill_en && (fill_idx == 1'(b))) begin
          vld_q[b] <= 1'b1;
          drt_q[b] <= 1'b0;
          tag_q[b] <= fill_row;
        end else if (dirty_en && (dirty_idx == 1'(b))) begin
          drt_q[b] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mru_q <= 1'b1;
    else if (touch_en) mru_q <= touch_idx;
  end

  assign hit      = |match;
  assign hit_idx  = match[1];
  assign vict_idx = !vld_q[0] ? 1'b0 : (!vld_q[1] ? 1'b1 : ~mru_q);
  assign vict_wb  = vld_q[vict_idx] && drt_q[vict_idx];
  assign vict_row = tag_q[vict_idx];
endmodule

// File: rtl/rbc_store.sv
module rbc_store #(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              fill_en,
  input  logic              wb_en,
  input  logic              fill_idx,
  input  logic [ROW_W-1:0]  fill_row,
  input  logic [ROW_W-1:0]  wb_row,
  input  logic              acc_en,
  input  logic              acc_idx,
  input  logic              acc_we,
  input  logic [COL_W-3:0]  acc_word,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NROWS  = 1 << ROW_W;
  localparam int NWORDS = 1 << (COL_W - 2);

  logic [DATA_W-1:0] arr_m [NROWS][NWORDS];
  logic [DATA_W-1:0] buf_m [2][NWORDS];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (wb_en) arr_m[wb_row][w] <= buf_m[fill_idx][w];
        buf_m[fill_idx][w] <= arr_m[fill_row][w];
      end
    end else if (acc_en && acc_we) begin
      buf_m[acc_idx][acc_word] <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en) rdata <= acc_we ? acc_wdata : buf_m[acc_idx][acc_word];
  end
endmodule

// File: rtl/dual_rb_bank_ctl.sv
module dual_rb_bank_ctl #(
  parameter int ROW_W    = 2,
  parameter int COL_W    = 11,
  parameter int DATA_W   = 32,
  parameter int HIT_LAT  = 4,
  parameter int MISS_LAT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int WORD_W = COL_W - 2;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [ROW_W-1:0]  in_row;
  logic [WORD_W-1:0] in_word;
  assign in_row  = req_addr[ADDR_W-1:COL_W];
  assign in_word = req_addr[COL_W-1:2];

  logic             hit, hit_idx, vict_idx, vict_wb;
  logic [ROW_W-1:0] vict_row;
  logic             idle, fill_en, done_en, fire, sel_idx;

  assign req_ready = idle && rst_sync_n;
  assign fire      = req_valid && req_ready;
  assign sel_idx   = hit ? hit_idx : vict_idx;

  logic [ROW_W-1:0]  q_row, q_wb_row;
  logic [WORD_W-1:0] q_word;
  logic [DATA_W-1:0] q_wdata;
  logic              q_we, q_idx, q_wb;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_row    <= '0;
      q_wb_row <= '0;
      q_word   <= '0;
      q_wdata  <= '0;
      q_we     <= 1'b0;
      q_idx    <= 1'b0;
      q_wb     <= 1'b0;
    end else if (fire) begin
      q_row    <= in_row;
      q_wb_row <= vict_row;
      q_word   <= in_word;
      q_wdata  <= req_wdata;
      q_we     <= req_write;
      q_idx    <= sel_idx;
      q_wb     <= !hit && vict_wb;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_valid <= 1'b0;
    else             rsp_valid <= done_en;
  end

  rbc_seq #(.HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(fire), .start_hit(hit),
    .idle(idle), .fill_en(fill_en), .done_en(done_en)
  );

  rbc_tags #(.ROW_W(ROW_W)) u_tags (
    .clk(clk), .rst_n(rst_sync_n), .look_row(in_row),
    .hit(hit), .hit_idx(hit_idx), .vict_idx(vict_idx), .vict_wb(vict_wb),
    .vict_row(vict_row), .touch_en(fire), .touch_idx(sel_idx),
    .fill_en(fill_en), .fill_idx(q_idx), .fill_row(q_row),
    .dirty_en(done_en && q_we), .dirty_idx(q_idx)
  );

  rbc_store #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .fill_en(fill_en), .wb_en(fill_en && q_wb), .fill_idx(q_idx),
    .fill_row(q_row), .wb_row(q_wb_row), .acc_en(done_en), .acc_idx(q_idx),
    .acc_we(q_we), .acc_word(q_word), .acc_wdata(q_wdata), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/rbc_chk.sv
module rbc_chk #(
  parameter int DATA_W   = 32,
  parameter int HIT_LAT  = 4,
  parameter int MISS_LAT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              fill_en
);
  logic [7:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_q <= 8'hff;
    else if (req_valid && req_ready) since_q <= 8'd0;
    else if (since_q != 8'hff)       since_q <= since_q + 8'd1;
  end

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  ready_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R2 R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (since_q == 8'(HIT_LAT) || since_q == 8'(MISS_LAT)));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));

  // R7
  fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (since_q == 8'd0));
endmodule

bind dual_rb_bank_ctl rbc_chk #(
  .DATA_W(DATA_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fill_en(fill_en)
);

// File: tb/dual_rb_bank_ctl_test.sv
module dual_rb_bank_ctl_test;
  localparam int ROW_W = 2, COL_W = 11, DW = 32, AW = ROW_W + COL_W;
  localparam int HL = 4, ML = 8;
  localparam int NW = 1 << (COL_W - 2);
  localparam int NR = 1 << ROW_W;

  logic clk, rst_n, req_valid, req_ready, req_write, rsp_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata;

  dual_rb_bank_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [DW-1:0] shadow [NR*NW];
  logic          known  [NR*NW];
  logic          m_vld  [2];
  logic [ROW_W-1:0] m_tag [2];
  logic          m_mru;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [ROW_W-1:0] row, output logic idx);
    idx = 1'b0;
    for (int b = 0; b < 2; b++) if (m_vld[b] && m_tag[b] == row) begin
      idx = 1'(b);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic model_victim();
    if (!m_vld[0]) return 1'b0;
    if (!m_vld[1]) return 1'b1;
    return ~m_mru;
  endfunction

  task automatic do_req(input bit we, input logic [ROW_W-1:0] row,
                        input int word, input logic [1:0] low,
                        input logic [DW-1:0] wd, input string req);
    logic hidx, b;
    bit   h;
    int   lat, exp_lat, key;
    h = model_hit(row, hidx);
    b = h ? hidx : model_victim();
    exp_lat = h ? HL : ML;
    key = int'(row) * NW + word;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = we;
    req_addr  = {row, 9'(word), low};
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      check(req_ready == 1'b0, "R4 ready low while busy", DW'(req_ready), 0);
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check(lat == exp_lat, h ? {req, " R2 hit latency"} : {req, " R3 miss latency"},
          DW'(lat), DW'(exp_lat));
    check(req_ready == 1'b1, "R4 ready back with response", DW'(req_ready), 1);
    if (we)
      check(rsp_rdata === wd, {req, " R9 write echo"}, rsp_rdata, wd);
    else if (known[key])
      check(rsp_rdata === shadow[key], {req, " R6 read data"}, rsp_rdata, shadow[key]);
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R5 single-cycle pulse", DW'(rsp_valid), 0);
    if (!h) begin
      m_vld[b] = 1'b1;
      m_tag[b] = row;
    end
    m_mru = b;
    if (we) begin
      shadow[key] = wd;
      known[key]  = 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR*NW; i++) known[i] = 1'b0;
    m_vld[0] = 1'b0; m_vld[1] = 1'b0;
    m_tag[0] = '0;   m_tag[1] = '0;
    m_mru = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle after reset, empty buffers (first access below is a miss)
    check(req_ready == 1'b1, "R1 ready after reset", DW'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", DW'(rsp_valid), 0);

    do_req(1, 2'd0, 5, 2'b00, 32'hA5A5_0001, "R1 first write");
    do_req(0, 2'd0, 5, 2'b00, 0, "R2 reread");
    do_req(1, 2'd1, 7, 2'b00, 32'h0BAD_F00D, "R7 second buffer");
    do_req(0, 2'd0, 5, 2'b00, 0, "R7 touch row0");
    do_req(0, 2'd2, 0, 2'b00, 0, "R7 evict lru row1");
    do_req(0, 2'd0, 5, 2'b00, 0, "R7 row0 kept");
    do_req(0, 2'd1, 7, 2'b00, 0, "R6 written back row1");
    // R8: low address bits ignored
    do_req(1, 2'd3, 9, 2'b11, 32'h1357_9BDF, "R8 write low bits 3");
    do_req(0, 2'd3, 9, 2'b00, 0, "R8 read low bits 0");
    do_req(0, 2'd3, 9, 2'b10, 0, "R8 read low bits 2");
    // R3: miss with dirty victim still takes MISS_LAT
    do_req(1, 2'd2, 1, 2'b00, 32'hCAFE_0002, "R3 dirty row2");
    do_req(0, 2'd0, 1, 2'b00, 0, "R3 miss evicting dirty");

    for (int i = 0; i < 400; i++) begin
      logic [ROW_W-1:0] row;
      int word;
      bit we;
      row  = ROW_W'($urandom_range(NR - 1));
      word = $urandom_range(7) * 61;
      we   = ($urandom_range(2) == 0);
      do_req(we, row, word, 2'($urandom_range(3)), $urandom(), "random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule